// File: doc/BRIEF.md
# Battery empty and full detector

This block watches periodic cell measurements and keeps two flags for a battery monitor: an empty flag with hysteresis and a full-qualified flag. On every cycle in which the sample strobe is high it looks at the cell voltage, the instantaneous and averaged charge current and a voltage-derived state of charge. It compares them against four programmable values that arrive as parallel inputs. On cycles without a strobe both flags hold their values.

The empty logic is a two-state machine. In state `EMPTY_CLEAR` it moves to `EMPTY_SET` (transition *trip*) when the cell voltage falls to or below the empty target. In `EMPTY_SET` it returns to `EMPTY_CLEAR` (transition *recover*) only when the voltage rises above the recovery level, which is scaled separately from the target. The full logic is a second two-state machine. It moves from `FULL_IDLE` to `FULL_QUAL` (transition *qualify*) when the state of charge is above the full threshold and both currents lie inside the termination window. It goes back (transition *drop*) on the first strobe at which any of these conditions fails. A strobe that keeps a machine's state (*stay*) changes nothing.

A host would normally load the empty word with 0xA561 (3.30 V target, 3.88 V recovery), the termination current with 0x0640 and the full threshold with 0x5F05.

Top module: `cell_limit_detector`

## Requirements
- R1: After reset both `empty_flag` and `full_flag` are 0.
- R2: On a strobe while not empty, if `vcell_mv` is less than or equal to 10 mV times the target field `empty_cfg[15:7]` (9 bits, unsigned), `empty_flag` is 1 from the next cycle.
- R3: While empty, a strobe with `vcell_mv` above 40 mV times the recovery field `empty_cfg[6:0]` (7 bits, unsigned) clears `empty_flag` on the next cycle. A strobe with `vcell_mv` at or below that level keeps the flag set, even when it is above the target.
- R4: On cycles with `sample_valid` low, both flags keep their value whatever the other inputs do.
- R5: On a strobe, `full_flag` becomes 1 on the next cycle when `soc_vf` is greater than `full_soc_thr` (both unsigned 16-bit) and each of `cur_inst` and `cur_avg` (signed two's complement) lies strictly between 0.125 and 1.25 times `term_cur` (signed).
- R6: `full_flag` is 0 on the cycle after any strobe at which one of the R5 conditions fails, including `soc_vf` equal to the threshold.
- R7: The window limits are exact. A current equal to exactly one eighth, or exactly five quarters, of the termination current is outside the window.
- R8: A current that is zero or negative never qualifies full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | Measurement strobe, one cycle per sample |
| vcell_mv | input | 16 | Cell voltage, unsigned, 1 mV per LSB |
| cur_inst | input | 16 | Instantaneous current, signed |
| cur_avg | input | 16 | Averaged current, signed |
| soc_vf | input | 16 | Voltage-derived state of charge, unsigned |
| empty_cfg | input | 16 | [15:7] target in 10 mV steps, [6:0] recovery in 40 mV steps |
| term_cur | input | 16 | Charge-termination current, signed, same scale as the currents |
| full_soc_thr | input | 16 | Full state-of-charge threshold, unsigned |
| empty_flag | output | 1 | Sticky empty indication with hysteresis |
| full_flag | output | 1 | Full-qualified indication |

## Verification
The assertions check on every cycle that both flags hold without a strobe. They also check that a strobe at or below the target sets the empty flag, that a strobe above recovery clears it, that a strobe in the gap between the two levels keeps it set, and that a failing threshold or a non-positive current removes full. The exactness of the window edges at one eighth and five quarters, and the combination of all three full conditions, come only from the bench. The bench runs directed edge values and constrained random currents clustered around both window limits.

// File: rtl/cld_pkg.sv
package cld_pkg;
    localparam int VOLT_W  = 16;
    localparam int CUR_W   = 16;
    localparam int SOC_W   = 16;
    localparam int VE_W    = 9;
    localparam int VR_W    = 7;
    localparam int VE_STEP = 10;
    localparam int VR_STEP = 40;
    localparam int THR_W   = VR_W + 6;

    localparam logic [15:0] EMPTY_CFG_DEFAULT = 16'hA561;
    localparam logic [15:0] TERM_CUR_DEFAULT  = 16'h0640;
    localparam logic [15:0] FULL_THR_DEFAULT  = 16'h5F05;

    typedef enum logic {
        EMPTY_CLEAR = 1'b0,
        EMPTY_SET   = 1'b1
    } empty_state_t;

    typedef enum logic {
        FULL_IDLE = 1'b0,
        FULL_QUAL = 1'b1
    } full_state_t;
endpackage

// File: rtl/cld_window_check.sv
module cld_window_check #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] term,
    output logic         in_window
);
    localparam int XW = W + 4;

    logic signed [XW-1:0] cur_x;
    logic signed [XW-1:0] term_x;
    logic signed [XW-1:0] cur_x8;
    logic signed [XW-1:0] cur_x4;
    logic signed [XW-1:0] term_x5;
    logic                 above_low;
    logic                 below_high;

    always_comb begin
        cur_x      = XW'(signed'(cur));
        term_x     = XW'(signed'(term));
        cur_x8     = cur_x <<< 3;
        cur_x4     = cur_x <<< 2;
        term_x5    = (term_x <<< 2) + term_x;
        above_low  = cur_x8 > term_x;
        below_high = cur_x4 < term_x5;
        in_window  = above_low && below_high;
    end
endmodule

// File: rtl/cld_empty_fsm.sv
module cld_empty_fsm
    import cld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [VOLT_W-1:0] vcell,
    input  logic [VE_W-1:0]   target_code,
    input  logic [VR_W-1:0]   recover_code,
    output logic              empty
);
    localparam int EW = (THR_W > VOLT_W) ? THR_W : VOLT_W;

    empty_state_t state_q;
    empty_state_t state_d;
    logic [EW-1:0] target_mv;
    logic [EW-1:0] recover_mv;
    logic [EW-1:0] vcell_x;
    logic          at_or_below_target;
    logic          above_recover;

    always_comb begin
        vcell_x    = EW'(vcell);
        target_mv  = (EW'(target_code) << 3) + (EW'(target_code) << 1);
        recover_mv = (EW'(recover_code) << 5) + (EW'(recover_code) << 3);
        at_or_below_target = vcell_x <= target_mv;
        above_recover      = vcell_x > recover_mv;
    end

    always_comb begin
        state_d = state_q;
        if (strobe) begin
            unique case (state_q)
                EMPTY_CLEAR: if (at_or_below_target) state_d = EMPTY_SET;
                EMPTY_SET:   if (above_recover)      state_d = EMPTY_CLEAR;
                default:     state_d = EMPTY_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EMPTY_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        empty = (state_q == EMPTY_SET);
    end
endmodule

// File: rtl/cld_full_fsm.sv
module cld_full_fsm
    import cld_pkg::*;
#(
    parameter int N_CUR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [SOC_W-1:0] soc,
    input  logic [SOC_W-1:0] soc_thr,
    input  logic [N_CUR-1:0] cur_ok,
    output logic             full
);
    full_state_t state_q;
    full_state_t state_d;
    logic        all_ok;

    always_comb begin
        all_ok = (soc > soc_thr) && (&cur_ok);
    end

    always_comb begin
        state_d = state_q;
        if (strobe) begin
            unique case (state_q)
                FULL_IDLE: if (all_ok)  state_d = FULL_QUAL;
                FULL_QUAL: if (!all_ok) state_d = FULL_IDLE;
                default:   state_d = FULL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FULL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        full = (state_q == FULL_QUAL);
    end
endmodule

// File: rtl/cell_limit_detector.sv
module cell_limit_detector
    import cld_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sample_valid,
    input  logic [15:0] vcell_mv,
    input  logic [15:0] cur_inst,
    input  logic [15:0] cur_avg,
    input  logic [15:0] soc_vf,
    input  logic [15:0] empty_cfg,
    input  logic [15:0] term_cur,
    input  logic [15:0] full_soc_thr,
    output logic        empty_flag,
    output logic        full_flag
);
    localparam int N_CUR = 2;

    logic [CUR_W-1:0] cur_vec [N_CUR];
    logic [N_CUR-1:0] cur_ok;

    always_comb begin
        cur_vec[0] = cur_inst;
        cur_vec[1] = cur_avg;
    end

    for (genvar g = 0; g < N_CUR; g++) begin : g_win
        cld_window_check #(.W(CUR_W)) u_win (
            .cur       (cur_vec[g]),
            .term      (term_cur),
            .in_window (cur_ok[g])
        );
    end

    cld_empty_fsm u_empty (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe       (sample_valid),
        .vcell        (vcell_mv),
        .target_code  (empty_cfg[15:7]),
        .recover_code (empty_cfg[6:0]),
        .empty        (empty_flag)
    );

    cld_full_fsm #(.N_CUR(N_CUR)) u_full (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (sample_valid),
        .soc     (soc_vf),
        .soc_thr (full_soc_thr),
        .cur_ok  (cur_ok),
        .full    (full_flag)
    );
endmodule

// File: rtl/cld_checker.sv
module cld_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sample_valid,
    input logic [15:0] vcell_mv,
    input logic [15:0] cur_inst,
    input logic [15:0] cur_avg,
    input logic [15:0] soc_vf,
    input logic [15:0] empty_cfg,
    input logic [15:0] full_soc_thr,
    input logic        empty_flag,
    input logic        full_flag
);
    logic [17:0] tgt_mv;
    logic [17:0] rec_mv;

    always_comb begin
        tgt_mv = 18'(empty_cfg[15:7]) * 18'd10;
        rec_mv = 18'(empty_cfg[6:0]) * 18'd40;
    end

    p_hold_nostrobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ($stable(empty_flag) && $stable(full_flag)));

    p_empty_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !empty_flag && (18'(vcell_mv) <= tgt_mv)) |=> empty_flag);

    p_empty_recover_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && empty_flag && (18'(vcell_mv) > rec_mv)) |=> !empty_flag);

    p_empty_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && empty_flag && (18'(vcell_mv) <= rec_mv)) |=> empty_flag);

    p_full_soc_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && (soc_vf <= full_soc_thr)) |=> !full_flag);

    p_full_nonpos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && ($signed(cur_inst) <= 0 || $signed(cur_avg) <= 0)) |=> !full_flag);
endmodule

bind cell_limit_detector cld_checker u_cld_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .vcell_mv     (vcell_mv),
    .cur_inst     (cur_inst),
    .cur_avg      (cur_avg),
    .soc_vf       (soc_vf),
    .empty_cfg    (empty_cfg),
    .full_soc_thr (full_soc_thr),
    .empty_flag   (empty_flag),
    .full_flag    (full_flag)
);

// File: tb/tb_cell_limit_detector.sv
module tb_cell_limit_detector;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [15:0] vcell_mv = '0;
    logic [15:0] cur_inst = '0;
    logic [15:0] cur_avg = '0;
    logic [15:0] soc_vf = '0;
    logic [15:0] empty_cfg = 16'hA561;
    logic [15:0] term_cur = 16'h0640;
    logic [15:0] full_soc_thr = 16'h5F05;
    logic        empty_flag;
    logic        full_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit exp_empty = 0;
    bit exp_full = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cell_limit_detector dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .vcell_mv(vcell_mv), .cur_inst(cur_inst), .cur_avg(cur_avg),
        .soc_vf(soc_vf), .empty_cfg(empty_cfg), .term_cur(term_cur),
        .full_soc_thr(full_soc_thr), .empty_flag(empty_flag), .full_flag(full_flag)
    );

    function automatic bit in_win(logic [15:0] c, logic [15:0] t);
        longint ci = longint'($signed(c));
        longint ti = longint'($signed(t));
        return (ci * 8 > ti) && (ci * 4 < ti * 5);
    endfunction

    function automatic void model_step();
        int v  = int'(vcell_mv);
        int ve = int'(empty_cfg[15:7]) * 10;
        int vr = int'(empty_cfg[6:0]) * 40;
        if (!exp_empty) begin
            if (v <= ve) exp_empty = 1;
        end else begin
            if (v > vr) exp_empty = 0;
        end
        exp_full = (soc_vf > full_soc_thr) && in_win(cur_inst, term_cur) && in_win(cur_avg, term_cur);
    endfunction

    task automatic check(string req, bit act, bit exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic strobe(logic [15:0] v, logic [15:0] ci, logic [15:0] ca, logic [15:0] s);
        vcell_mv = v; cur_inst = ci; cur_avg = ca; soc_vf = s;
        sample_valid = 1'b1;
        model_step();
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic strobe_chk(string req, logic [15:0] v, logic [15:0] ci, logic [15:0] ca, logic [15:0] s);
        strobe(v, ci, ca, s);
        check(req, empty_flag, exp_empty, "empty_flag");
        check(req, full_flag, exp_full, "full_flag");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", empty_flag, 1'b0, "empty after reset");
        check("R1", full_flag, 1'b0, "full after reset");

        // R2 target 3300 mV from 0xA561: boundary values
        strobe_chk("R2", 16'd3301, 16'd0, 16'd0, 16'd0);
        strobe_chk("R2", 16'd3300, 16'd0, 16'd0, 16'd0);
        check("R2", empty_flag, 1'b1, "empty at exactly target");
        // R3 recovery 3880 mV: inside the hysteresis gap stays set
        strobe_chk("R3", 16'd3600, 16'd0, 16'd0, 16'd0);
        strobe_chk("R3", 16'd3880, 16'd0, 16'd0, 16'd0);
        check("R3", empty_flag, 1'b1, "empty held at recovery level");
        strobe_chk("R3", 16'd3881, 16'd0, 16'd0, 16'd0);
        check("R3", empty_flag, 1'b0, "empty cleared above recovery");

        // R4 no strobe: inputs that would trip are ignored
        vcell_mv = 16'd100;
        repeat (5) @(negedge clk);
        check("R4", empty_flag, 1'b0, "empty held without strobe");

        // R5 qualify full, term 1600: window (200,2000)
        strobe_chk("R5", 16'd4100, 16'd300, 16'd1000, 16'h6000);
        check("R5", full_flag, 1'b1, "full qualified");
        // R4 no strobe: failing conditions ignored
        soc_vf = 16'd0; cur_inst = 16'hFFFF;
        repeat (4) @(negedge clk);
        check("R4", full_flag, 1'b1, "full held without strobe");
        // R6 soc equal to threshold drops
        strobe_chk("R6", 16'd4100, 16'd300, 16'd1000, 16'h5F05);
        check("R6", full_flag, 1'b0, "full dropped at soc==thr");
        // R7 exact edges
        strobe_chk("R7", 16'd4100, 16'd201, 16'd1999, 16'h6000);
        strobe_chk("R7", 16'd4100, 16'd200, 16'd1000, 16'h6000);
        strobe_chk("R7", 16'd4100, 16'd1000, 16'd2000, 16'h6000);
        strobe_chk("R7", 16'd4100, 16'd1999, 16'd201, 16'h6000);
        // R8 negative and zero currents
        strobe_chk("R8", 16'd4100, 16'hFF00, 16'd1000, 16'h6000);
        strobe_chk("R8", 16'd4100, 16'd1000, 16'd0, 16'h6000);

        // R5 R6 R7 random: terms and currents clustered near limits
        for (int k = 0; k < 400; k++) begin
            int t = 8 + int'($urandom_range(0, 3000));
            int c1, c2;
            case ($urandom_range(0, 3))
                0: c1 = t / 8 + int'($urandom_range(0, 6)) - 3;
                1: c1 = (t * 5) / 4 + int'($urandom_range(0, 6)) - 3;
                2: c1 = int'($urandom_range(0, 4000)) - 500;
                default: c1 = t / 2;
            endcase
            c2 = ($urandom_range(0, 1) == 1) ? t : c1;
            if (k % 50 == 7) empty_cfg = 16'($urandom());
            term_cur = 16'(t);
            full_soc_thr = 16'($urandom_range(20000, 30000));
            strobe_chk((k % 2 == 0) ? "R5" : "R6",
                       16'($urandom_range(0, 6000)), 16'(c1), 16'(c2),
                       16'($urandom_range(18000, 32000)));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule